// File: doc/BRIEF.md
# Alternating-Cycle SERDES Link Manager

This block sits between a 16-bit parallel serializer/deserializer pair and the user logic on each side of a board-to-board link. It runs entirely from one free-running reference clock, which it also hands to the serializer as its transmit clock. The transmit cycles are split into two kinds that alternate. On a fill cycle the block raises a single control pin, and the serializer inserts its own sync/idle pattern in response. On a payload cycle the block forwards the user's word. The 16 user bus bits are driven by separate, unrelated devices, so each bit passes through a chain of flip-flops before it is used.

On the receive side, the deserializer flags the words that carry control or idle codes. The block treats a flagged word as the remote end's fill cycle. It accepts only the unflagged word that comes right after one, so the user side never sees link-maintenance traffic. Every accepted word produces a one-cycle valid strobe, and between strobes the output word holds its last value. When the loss-of-signal input is asserted, three things happen: the link-up status drops, nothing is accepted, and every transmit cycle becomes a fill cycle. The phase counter keeps running during this time, so the alternation picks up again with the same parity once the signal returns.

With a 100 MHz reference, the user bus is sampled at an effective 50 MHz in each direction.

Top module: `link_phase_mgr`

## Requirements
- R1: `ser_tx_clk` follows `clk_ref`: it is high while the reference is high and low while it is low.
- R2: Counting rising edges of `clk_ref` after reset release from 1, `ser_tx_fill` is 1 after every odd edge and 0 after every even edge, provided loss-of-signal is not forcing fill. The first cycle after reset is therefore a fill cycle, and two payload cycles are never adjacent.
- R3: With `ZERO_FILL`=1, `ser_tx_data` is all zeros on every cycle where `ser_tx_fill` is 1.
- R4: On a payload cycle after edge e, `ser_tx_data` equals the `usr_tx_word` value that was present at edge e-SYNC_STAGES. The default `SYNC_STAGES` is 2, so the total transmit latency is SYNC_STAGES+1 edges.
- R5: A received word is accepted when two conditions hold. It is sampled with `ser_rx_ctrl`=0. The word sampled on the edge before it had `ser_rx_ctrl`=1. Loss-of-signal must be low at both of those samples. The word sampled at edge e appears on `usr_rx_word` after edge e+1, with `usr_rx_valid`=1 for exactly that one cycle.
- R6: In every cycle where `usr_rx_valid` is 0, `usr_rx_word` keeps its previous value. Unflagged words that do not directly follow a flagged word are discarded.
- R7: If `ser_rx_los` is 1 at edge e, then after edge e+1 `link_up` is 0, `ser_tx_fill` is 1 and `usr_rx_valid` is 0. Once loss-of-signal clears, `link_up` returns to 1 with the same two-edge latency.
- R8: During reset `ser_tx_fill` is 1, `ser_tx_data`, `usr_rx_word` and `usr_rx_valid` are 0, and `link_up` is 0.
- R9: Loss-of-signal does not stop the phase counter. After recovery, payload cycles again fall after even edges, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock, sole clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_tx_word | input | W | User word to transmit, bits asynchronous to each other |
| ser_tx_clk | output | 1 | Transmit clock to the serializer |
| ser_tx_data | output | W | Parallel word to the serializer |
| ser_tx_fill | output | 1 | Requests serializer-generated sync/idle for this cycle |
| ser_rx_data | input | W | Parallel word from the deserializer |
| ser_rx_ctrl | input | 1 | Deserializer flag: current word is a control/idle code |
| ser_rx_los | input | 1 | Deserializer loss-of-signal |
| usr_rx_word | output | W | Last accepted received word |
| usr_rx_valid | output | 1 | One-cycle strobe per accepted word |
| link_up | output | 1 | Link status, low while loss-of-signal is seen |

## Verification
The bench builds the block with W=8, SYNC_STAGES=2 and ZERO_FILL=1. The narrow width lets a single run push every one of the 256 words through the transmit path and, separately, through the receive gate. An arithmetic reference model predicts all outputs on every cycle from the recorded stimulus. Irregular flag patterns exercise rejection of unflagged words that arrive without a preceding flagged word. Two loss-of-signal bursts of different length and parity check the forced fill, the dropped status and the preserved phase parity after recovery.

// File: rtl/link_mgr_pkg.sv
package link_mgr_pkg;

   typedef enum logic {
      PH_FILL = 1'b0,
      PH_DATA = 1'b1
   } phase_e;

   function automatic phase_e next_phase(input phase_e cur);
      return (cur == PH_FILL) ? PH_DATA : PH_FILL;
   endfunction

endpackage

// File: rtl/lm_sync_chain.sv
module lm_sync_chain #(
   parameter int W       = 16,
   parameter int STAGES  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("lm_sync_chain: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[LAST];

endmodule

// File: rtl/lm_tx_mux.sv
module lm_tx_mux
   import link_mgr_pkg::*;
#(
   parameter int W         = 16,
   parameter bit ZERO_FILL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] word_sync,
   input  logic         los_q,
   output logic         fill,
   output logic [W-1:0] data
);

   phase_e       phase_q;
   logic         fill_q;
   logic [W-1:0] data_q;
   logic         fill_d;

   assign fill_d = (phase_q == PH_FILL) || los_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FILL;
         fill_q  <= 1'b1;
      end else begin
         phase_q <= next_phase(phase_q);
         fill_q  <= fill_d;
      end
   end

   if (ZERO_FILL) begin : g_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      data_q <= '0;
         else if (fill_d) data_q <= '0;
         else             data_q <= word_sync;
      end
   end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       data_q <= '0;
         else if (!fill_d) data_q <= word_sync;
      end
   end

   assign fill = fill_q;
   assign data = data_q;

endmodule

// File: rtl/lm_rx_gate.sv
module lm_rx_gate #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rx_data,
   input  logic         rx_ctrl,
   input  logic         rx_los,
   output logic [W-1:0] word,
   output logic         valid,
   output logic         up,
   output logic         los_q
);

   logic [W-1:0] data_q;
   logic         ctrl_q;
   logic         los_r;
   logic         expect_q;
   logic         accept;
   logic [W-1:0] word_q;
   logic         valid_q;
   logic         up_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ctrl_q <= 1'b0;
         los_r  <= 1'b1;
      end else begin
         data_q <= rx_data;
         ctrl_q <= rx_ctrl;
         los_r  <= rx_los;
      end
   end

   assign accept = expect_q && !ctrl_q && !los_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expect_q <= 1'b0;
         word_q   <= '0;
         valid_q  <= 1'b0;
         up_q     <= 1'b0;
      end else begin
         expect_q <= ctrl_q && !los_r;
         valid_q  <= accept;
         up_q     <= !los_r;
         if (accept) word_q <= data_q;
      end
   end

   assign word  = word_q;
   assign valid = valid_q;
   assign up    = up_q;
   assign los_q = los_r;

endmodule

// File: rtl/link_phase_mgr.sv
module link_phase_mgr #(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit ZERO_FILL   = 1'b1
) (
   input  logic         clk_ref,
   input  logic         rst_n,
   input  logic [W-1:0] usr_tx_word,
   output logic         ser_tx_clk,
   output logic [W-1:0] ser_tx_data,
   output logic         ser_tx_fill,
   input  logic [W-1:0] ser_rx_data,
   input  logic         ser_rx_ctrl,
   input  logic         ser_rx_los,
   output logic [W-1:0] usr_rx_word,
   output logic         usr_rx_valid,
   output logic         link_up
);

   if (W < 1) begin : g_bad_width
      $error("link_phase_mgr: W must be positive");
   end

   logic [W-1:0] word_sync;
   logic         los_q;

   assign ser_tx_clk = clk_ref;

   lm_sync_chain #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .din   (usr_tx_word),
      .dout  (word_sync)
   );

   lm_tx_mux #(.W(W), .ZERO_FILL(ZERO_FILL)) u_tx (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .word_sync (word_sync),
      .los_q     (los_q),
      .fill      (ser_tx_fill),
      .data      (ser_tx_data)
   );

   lm_rx_gate #(.W(W)) u_rx (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .rx_data (ser_rx_data),
      .rx_ctrl (ser_rx_ctrl),
      .rx_los  (ser_rx_los),
      .word    (usr_rx_word),
      .valid   (usr_rx_valid),
      .up      (link_up),
      .los_q   (los_q)
   );

endmodule

// File: rtl/lm_checker.sv
module lm_checker #(
   parameter int W         = 16,
   parameter bit ZERO_FILL = 1'b1
) (
   input logic         clk_ref,
   input logic         rst_n,
   input logic         ser_tx_fill,
   input logic [W-1:0] ser_tx_data,
   input logic         ser_rx_los,
   input logic [W-1:0] usr_rx_word,
   input logic         usr_rx_valid,
   input logic         link_up
);

   // R2: a payload cycle is always followed by a fill cycle
   p_no_adjacent_data_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !ser_tx_fill |=> ser_tx_fill);

   if (ZERO_FILL) begin : g_zero_chk
      // R3: the data lines are quiet on fill cycles
      p_fill_quiet_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
         ser_tx_fill |-> (ser_tx_data == '0));
   end

   // R5: the valid strobe lasts exactly one cycle
   p_single_strobe_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      usr_rx_valid |=> !usr_rx_valid);

   // R6: the received word holds whenever there is no strobe
   p_hold_word_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !usr_rx_valid |-> $stable(usr_rx_word));

   // R7: loss of signal drops the status two edges later
   p_los_down_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $past(ser_rx_los, 2) |-> !link_up);

   // R7: loss of signal forces fill and blocks acceptance
   p_los_fill_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $past(ser_rx_los, 2) |-> (ser_tx_fill && !usr_rx_valid));

endmodule

bind link_phase_mgr lm_checker #(.W(W), .ZERO_FILL(ZERO_FILL)) u_lm_checker (
   .clk_ref      (clk_ref),
   .rst_n        (rst_n),
   .ser_tx_fill  (ser_tx_fill),
   .ser_tx_data  (ser_tx_data),
   .ser_rx_los   (ser_rx_los),
   .usr_rx_word  (usr_rx_word),
   .usr_rx_valid (usr_rx_valid),
   .link_up      (link_up)
);

// File: tb/test_link_phase_mgr.sv
module test_link_phase_mgr;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int STAGES     = 2;
   localparam int LAST_CYC   = 905;
   localparam int HIST       = 1024;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] usr_tx_word = '0;
   logic         ser_tx_clk;
   logic [W-1:0] ser_tx_data;
   logic         ser_tx_fill;
   logic [W-1:0] ser_rx_data = '0;
   logic         ser_rx_ctrl = 1'b0;
   logic         ser_rx_los = 1'b1;
   logic [W-1:0] usr_rx_word;
   logic         usr_rx_valid;
   logic         link_up;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   logic [W-1:0] h_tx [HIST];
   logic [W-1:0] h_rd [HIST];
   logic         h_rc [HIST];
   logic         h_rl [HIST];
   logic [W-1:0] exp_word = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   link_phase_mgr #(.W(W), .SYNC_STAGES(STAGES), .ZERO_FILL(1'b1)) i_link_phase_mgr (
      .clk_ref      (clk),
      .rst_n        (rst_n),
      .usr_tx_word  (usr_tx_word),
      .ser_tx_clk   (ser_tx_clk),
      .ser_tx_data  (ser_tx_data),
      .ser_tx_fill  (ser_tx_fill),
      .ser_rx_data  (ser_rx_data),
      .ser_rx_ctrl  (ser_rx_ctrl),
      .ser_rx_los   (ser_rx_los),
      .usr_rx_word  (usr_rx_word),
      .usr_rx_valid (usr_rx_valid),
      .link_up      (link_up)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
      end
   endtask

   task automatic drive(input int e);
      logic los;
      logic rc;
      los = ((e >= 700 && e < 720) || (e >= 800 && e < 803));
      if (e >= 600 && e < 700)      rc = ((e % 3) == 0);
      else if (e >= 850 && e < 860) rc = 1'b1;
      else                          rc = e[0];
      h_tx[e] = W'(e >> 1);
      h_rd[e] = (e < 600) ? (W'(e >> 1) ^ 8'hA5) : (W'(e) ^ 8'h3C);
      h_rc[e] = rc;
      h_rl[e] = los;
      usr_tx_word = h_tx[e];
      ser_rx_data = h_rd[e];
      ser_rx_ctrl = rc;
      ser_rx_los  = los;
   endtask

   task automatic model_check(input int e);
      logic exp_fill;
      logic exp_valid;
      logic [W-1:0] exp_data;
      exp_fill  = e[0] || h_rl[e-2];                       // R2, R7, R9
      exp_data  = exp_fill ? '0 : h_tx[e-STAGES-1];         // R3, R4
      exp_valid = h_rc[e-3] && !h_rl[e-3] && !h_rc[e-2] && !h_rl[e-2];  // R5
      if (exp_valid) exp_word = h_rd[e-2];
      check("R2/R7/R9 fill", 32'(ser_tx_fill), 32'(exp_fill));
      check(exp_fill ? "R3 fill data" : "R4 payload data", 32'(ser_tx_data), 32'(exp_data));
      check("R5 valid", 32'(usr_rx_valid), 32'(exp_valid));
      check(exp_valid ? "R5 rx word" : "R6 rx hold", 32'(usr_rx_word), 32'(exp_word));
      check("R7 link_up", 32'(link_up), 32'(!h_rl[e-2]));
      check("R1 tx clk low", 32'(ser_tx_clk), 32'd0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 fill", 32'(ser_tx_fill), 32'd1);
      check("R8 data", 32'(ser_tx_data), 32'd0);
      check("R8 valid", 32'(usr_rx_valid), 32'd0);
      check("R8 word", 32'(usr_rx_word), 32'd0);
      check("R8 link_up", 32'(link_up), 32'd0);
      @(posedge clk);
      #1;
      check("R1 tx clk high", 32'(ser_tx_clk), 32'd1);
      @(negedge clk);
      rst_n = 1'b1;
      drive(0);
      for (int e = 1; e <= LAST_CYC; e++) begin
         @(negedge clk);
         if (e >= 3) model_check(e);
         drive(e);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule